// File: doc/BRIEF.md
# Address-Shuffling Block Remapper

This block sits between a processor's secure side and external memory and breaks the fixed link between a logical block number and the external slot where that block is stored. A small on-chip buffer holds the blocks that are currently inside the security boundary. A map table holds, for every block outside, the slot it occupies now. A request for a buffered block is answered on chip with no bus traffic. A request for an outside block reads it from its current slot. Once the buffer is full, a randomly chosen resident block is then written into the slot that was just emptied and the table is updated. Repeated accesses to the same block therefore wander across external addresses.

Block contents and encryption are handled elsewhere. On the memory port the payload is only the block number. Requests use a valid/ready handshake and each one gets a single-cycle response pulse. The external read and write ports each use valid/ready. Read data returns as a one-cycle pulse at least one cycle after the read command is accepted. After reset the block initialises the table for N_BLOCKS cycles and accepts no request during that time.

Top module: `shuffle_obfuscator`

## Requirements
- R1: After reset, rsp_valid, mem_rd_valid and mem_wr_valid are low, and req_ready stays low for the N_BLOCKS-cycle table sweep. After the sweep every block b is mapped to external slot b.
- R2: A request for a block that is not buffered causes exactly one external read, at the slot currently mapped to that block. rsp_id equals the block number returned by memory, and rsp_valid is a one-cycle pulse.
- R3: While fewer than K blocks are buffered, a miss only inserts the fetched block and issues no external write.
- R4: With the buffer full, each miss issues exactly one write, after the read data has arrived, to the slot that was just read. The written block is neither the block just fetched nor the most recently requested block.
- R5: A block that was written out is later read back from the slot it was written to.
- R6: A request for a buffered block gets rsp_valid in the cycle after acceptance, with rsp_id equal to req_id, and causes no external read or write.
- R7: The victim is drawn by a 16-bit maximal-length LFSR from the K-1 entries other than the most recently touched one. Draws outside that range are rejected and the next LFSR value is tried, so over a long run many different blocks get evicted.
- R8: mem_rd_valid and mem_wr_valid, with their slot and id, stay stable until ready is seen. req_ready is low while either bus request is pending.
- R9: The blocks outside the buffer occupy distinct slots. Exactly one slot is empty per buffered block, and a write only ever lands in an empty slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_id | input | log2(N_BLOCKS) | Requested logical block |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_id | output | log2(N_BLOCKS) | Block delivered to the requester |
| mem_rd_valid | output | 1 | External read command present |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_slot | output | log2(N_BLOCKS) | External slot to read |
| mem_rdata_valid | input | 1 | Read data pulse |
| mem_rdata_id | input | log2(N_BLOCKS) | Block number stored in the slot read |
| mem_wr_valid | output | 1 | External write command present |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_slot | output | log2(N_BLOCKS) | External slot to write |
| mem_wr_id | output | log2(N_BLOCKS) | Evicted block being written |

## Verification
A hit's response is due in the cycle right after the accepting edge. The bench samples on the falling edge that follows acceptance and expects rsp_valid there, with no external transaction counted in between. On a miss, the read command appears two edges after acceptance, because the table is read synchronously. The response follows one edge after the read data during fill, or one edge after the accepted write once the buffer is full. Since the memory model inserts random ready and data delays, the bench waits for rsp_valid and then checks how many reads and writes it saw. The bench drives each ready on a falling edge and decides there whether the transfer completes at the next rising edge, so slot checks happen before the design moves on.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [2:0] {
    ST_INIT   = 3'd0,
    ST_IDLE   = 3'd1,
    ST_LOOK   = 3'd2,
    ST_RDREQ  = 3'd3,
    ST_RDWAIT = 3'd4,
    ST_PICK   = 3'd5,
    ST_WRITE  = 3'd6
  } shf_state_e;

  // x^16 + x^14 + x^13 + x^11 + 1, right-shifting Galois form
  localparam logic [15:0] SHF_TAPS16 = 16'hB400;

endpackage

// File: rtl/shf_lfsr.sv
module shf_lfsr #(
  parameter int W = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter int OUT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  output logic [OUT_W-1:0] rnd
);

  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= SEED;
    end else begin
      q <= {1'b0, q[W-1:1]} ^ (q[0] ? TAPS : '0);
    end
  end

  assign rnd = q[OUT_W-1:0];

endmodule

// File: rtl/shf_map_table.sv
module shf_map_table #(
  parameter int DEPTH = 16,
  parameter int AW = 4,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/shf_entry_match.sv
module shf_entry_match #(
  parameter int K = 4,
  parameter int IDW = 4,
  parameter int KW = 2
) (
  input  logic [IDW-1:0] key,
  input  logic [IDW-1:0] ent_id [K],
  input  logic [K-1:0]   ent_vld,
  output logic           hit,
  output logic [KW-1:0]  idx
);

  logic [K-1:0] eq;

  for (genvar g = 0; g < K; g++) begin : g_cmp
    assign eq[g] = ent_vld[g] && (ent_id[g] == key);
  end

  always_comb begin
    hit = |eq;
    idx = '0;
    for (int i = 0; i < K; i++) begin
      if (eq[i]) idx = KW'(i);
    end
  end

endmodule

// File: rtl/shuffle_obfuscator.sv
module shuffle_obfuscator
  import shf_pkg::*;
#(
  parameter int N_BLOCKS = 16,
  parameter int K = 4,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int IDW = (N_BLOCKS > 1) ? $clog2(N_BLOCKS) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [IDW-1:0] req_id,
  output logic           rsp_valid,
  output logic [IDW-1:0] rsp_id,
  output logic           mem_rd_valid,
  input  logic           mem_rd_ready,
  output logic [IDW-1:0] mem_rd_slot,
  input  logic           mem_rdata_valid,
  input  logic [IDW-1:0] mem_rdata_id,
  output logic           mem_wr_valid,
  input  logic           mem_wr_ready,
  output logic [IDW-1:0] mem_wr_slot,
  output logic [IDW-1:0] mem_wr_id
);

  // K must be at least 3 so that K-1 candidates exist
  localparam int KW = $clog2(K);
  localparam int RW = (K > 2) ? $clog2(K - 1) : 1;
  localparam int FW = $clog2(K + 1);
  localparam logic [FW-1:0]  FILL_FULL = FW'(K);
  localparam logic [IDW-1:0] LAST_BLK  = IDW'(N_BLOCKS - 1);
  localparam logic [RW:0]    CAND_CNT  = (RW + 1)'(K - 1);

  shf_state_e     state;
  logic [IDW-1:0] init_cnt;
  logic [IDW-1:0] slot_q;
  logic [IDW-1:0] fetch_q;
  logic [IDW-1:0] ent_id [K];
  logic [K-1:0]   ent_vld;
  logic [KW-1:0]  mru_q;
  logic [KW-1:0]  vict_q;
  logic [FW-1:0]  fill_q;

  logic           hit;
  logic [KW-1:0]  hit_idx;
  logic [RW-1:0]  rsel;
  logic           pick_ok;
  logic [KW-1:0]  pick_idx;

  logic           tbl_we;
  logic [IDW-1:0] tbl_waddr;
  logic [IDW-1:0] tbl_wdata;
  logic [IDW-1:0] tbl_rdata;

  // Lookup in the on-chip buffer
  shf_entry_match #(.K(K), .IDW(IDW), .KW(KW)) match_i (
    .key     (req_id),
    .ent_id  (ent_id),
    .ent_vld (ent_vld),
    .hit     (hit),
    .idx     (hit_idx)
  );

  // Random source for victim choice
  shf_lfsr #(.W(16), .TAPS(SHF_TAPS16), .SEED(LFSR_SEED), .OUT_W(RW)) lfsr_i (
    .clk (clk),
    .rst (rst),
    .rnd (rsel)
  );

  // Logical block -> external slot
  shf_map_table #(.DEPTH(N_BLOCKS), .AW(IDW), .DW(IDW)) table_i (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_waddr),
    .wdata (tbl_wdata),
    .raddr (req_id),
    .rdata (tbl_rdata)
  );

  // Candidate index skips the most recently touched entry
  always_comb begin
    pick_ok  = ({1'b0, rsel} < CAND_CNT);
    pick_idx = (KW'(rsel) >= mru_q) ? KW'(rsel) + KW'(1) : KW'(rsel);
  end

  always_comb begin
    tbl_we    = 1'b0;
    tbl_waddr = ent_id[vict_q];
    tbl_wdata = slot_q;
    if (state == ST_INIT) begin
      tbl_we    = 1'b1;
      tbl_waddr = init_cnt;
      tbl_wdata = init_cnt;
    end else if (state == ST_WRITE && mem_wr_ready) begin
      tbl_we    = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_INIT;
      init_cnt  <= '0;
      slot_q    <= '0;
      fetch_q   <= '0;
      ent_vld   <= '0;
      mru_q     <= '0;
      vict_q    <= '0;
      fill_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_id    <= '0;
      for (int i = 0; i < K; i++) ent_id[i] <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_INIT: begin
          init_cnt <= init_cnt + IDW'(1);
          if (init_cnt == LAST_BLK) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (req_valid) begin
            if (hit) begin
              rsp_valid <= 1'b1;
              rsp_id    <= ent_id[hit_idx];
              mru_q     <= hit_idx;
            end else begin
              state <= ST_LOOK;
            end
          end
        end
        ST_LOOK: begin
          slot_q <= tbl_rdata;
          state  <= ST_RDREQ;
        end
        ST_RDREQ: begin
          if (mem_rd_ready) state <= ST_RDWAIT;
        end
        ST_RDWAIT: begin
          if (mem_rdata_valid) begin
            fetch_q <= mem_rdata_id;
            if (fill_q < FILL_FULL) begin
              ent_id[KW'(fill_q)]  <= mem_rdata_id;
              ent_vld[KW'(fill_q)] <= 1'b1;
              mru_q     <= KW'(fill_q);
              fill_q    <= fill_q + FW'(1);
              rsp_valid <= 1'b1;
              rsp_id    <= mem_rdata_id;
              state     <= ST_IDLE;
            end else begin
              state <= ST_PICK;
            end
          end
        end
        ST_PICK: begin
          if (pick_ok) begin
            vict_q <= pick_idx;
            state  <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (mem_wr_ready) begin
            ent_id[vict_q] <= fetch_q;
            mru_q     <= vict_q;
            rsp_valid <= 1'b1;
            rsp_id    <= fetch_q;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_INIT;
      endcase
    end
  end

  assign req_ready    = (state == ST_IDLE);
  assign mem_rd_valid = (state == ST_RDREQ);
  assign mem_rd_slot  = slot_q;
  assign mem_wr_valid = (state == ST_WRITE);
  assign mem_wr_slot  = slot_q;
  assign mem_wr_id    = ent_id[vict_q];

endmodule

// File: rtl/shf_obfuscator_chk.sv
module shf_obfuscator_chk #(
  parameter int N_BLOCKS = 16,
  parameter int K = 4,
  localparam int IDW = (N_BLOCKS > 1) ? $clog2(N_BLOCKS) : 1
) (
  input logic           clk,
  input logic           rst,
  input logic           req_valid,
  input logic           req_ready,
  input logic [IDW-1:0] req_id,
  input logic           lookup_hit,
  input logic           rsp_valid,
  input logic [IDW-1:0] rsp_id,
  input logic           mem_rd_valid,
  input logic           mem_rd_ready,
  input logic [IDW-1:0] mem_rd_slot,
  input logic           mem_rdata_valid,
  input logic [IDW-1:0] mem_rdata_id,
  input logic           mem_wr_valid,
  input logic           mem_wr_ready,
  input logic [IDW-1:0] mem_wr_slot,
  input logic [IDW-1:0] mem_wr_id
);

  localparam int CW = $clog2(K + 2);
  localparam logic [CW-1:0] CNT_SAT = CW'(K + 1);

  logic [IDW-1:0] last_rd_slot_q;
  logic [IDW-1:0] last_fetch_q;
  logic [CW-1:0]  fetch_cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_rd_slot_q <= '0;
      last_fetch_q   <= '0;
      fetch_cnt_q    <= '0;
    end else begin
      if (mem_rd_valid && mem_rd_ready) last_rd_slot_q <= mem_rd_slot;
      if (mem_rdata_valid) begin
        last_fetch_q <= mem_rdata_id;
        if (fetch_cnt_q != CNT_SAT) fetch_cnt_q <= fetch_cnt_q + CW'(1);
      end
    end
  end

  // R6
  hit_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && lookup_hit) |=> (rsp_valid && rsp_id == $past(req_id)));

  // R6
  hit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && lookup_hit) |=> (!mem_rd_valid && !mem_wr_valid));

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_slot)));

  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_slot) && $stable(mem_wr_id)));

  // R8
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid || mem_wr_valid) |-> !req_ready);

  // R4
  wr_slot_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> (mem_wr_slot == last_rd_slot_q));

  // R4
  wr_not_fetched_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> (mem_wr_id != last_fetch_q));

  // R3
  fill_no_wr_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> (fetch_cnt_q == CNT_SAT));

endmodule

bind shuffle_obfuscator shf_obfuscator_chk #(.N_BLOCKS(N_BLOCKS), .K(K)) chk_i (
  .clk             (clk),
  .rst             (rst),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .req_id          (req_id),
  .lookup_hit      (hit),
  .rsp_valid       (rsp_valid),
  .rsp_id          (rsp_id),
  .mem_rd_valid    (mem_rd_valid),
  .mem_rd_ready    (mem_rd_ready),
  .mem_rd_slot     (mem_rd_slot),
  .mem_rdata_valid (mem_rdata_valid),
  .mem_rdata_id    (mem_rdata_id),
  .mem_wr_valid    (mem_wr_valid),
  .mem_wr_ready    (mem_wr_ready),
  .mem_wr_slot     (mem_wr_slot),
  .mem_wr_id       (mem_wr_id)
);

// File: tb/shuffle_obfuscator_tb_top.sv
module shuffle_obfuscator_tb_top;

  localparam int NB = 16;
  localparam int KE = 4;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [IW-1:0] req_id = '0;
  logic          rsp_valid;
  logic [IW-1:0] rsp_id;
  logic          mem_rd_valid;
  logic          mem_rd_ready = 1'b0;
  logic [IW-1:0] mem_rd_slot;
  logic          mem_rdata_valid = 1'b0;
  logic [IW-1:0] mem_rdata_id = '0;
  logic          mem_wr_valid;
  logic          mem_wr_ready = 1'b0;
  logic [IW-1:0] mem_wr_slot;
  logic [IW-1:0] mem_wr_id;

  shuffle_obfuscator #(.N_BLOCKS(NB), .K(KE)) dut_i (
    .clk (clk), .rst (rst),
    .req_valid (req_valid), .req_ready (req_ready), .req_id (req_id),
    .rsp_valid (rsp_valid), .rsp_id (rsp_id),
    .mem_rd_valid (mem_rd_valid), .mem_rd_ready (mem_rd_ready), .mem_rd_slot (mem_rd_slot),
    .mem_rdata_valid (mem_rdata_valid), .mem_rdata_id (mem_rdata_id),
    .mem_wr_valid (mem_wr_valid), .mem_wr_ready (mem_wr_ready),
    .mem_wr_slot (mem_wr_slot), .mem_wr_id (mem_wr_id)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // Bench model of external memory and mapping, built from observed traffic
  int btab [NB];
  int mblk [NB];
  bit res [NB];
  bit [NB-1:0] vict_seen;
  int cur_want = 0;
  int mru_blk = -1;
  int nres = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  int rdat_cnt = 0;
  int rdat_id = 0;
  int last_rd_slot = -1;
  bit rd_stall = 1'b0;
  bit wr_stall = 1'b0;
  int stall_rd_slot = 0;
  int stall_wr_slot = 0;
  int stall_wr_id = 0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int slot_of(input int b);
    return btab[b];
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // Memory responder: decides ready at each falling edge
  always @(negedge clk) begin
    bit rr;
    bit wr;
    if (rst) begin
      for (int i = 0; i < NB; i++) begin
        btab[i] = i; mblk[i] = i; res[i] = 1'b0;
      end
      vict_seen = '0;
      mem_rd_ready = 1'b0; mem_wr_ready = 1'b0; mem_rdata_valid = 1'b0;
      rdat_cnt = 0; rd_stall = 1'b0; wr_stall = 1'b0;
    end else begin
      mem_rdata_valid = 1'b0;
      if (rdat_cnt > 0) begin
        rdat_cnt--;
        if (rdat_cnt == 0) begin
          mem_rdata_valid = 1'b1;
          mem_rdata_id = IW'(rdat_id);
        end
      end
      // R8: command held while not accepted
      if (rd_stall)
        chk(mem_rd_valid && int'(mem_rd_slot) == stall_rd_slot, "R8", "read held", int'(mem_rd_slot), stall_rd_slot);
      if (wr_stall)
        chk(mem_wr_valid && int'(mem_wr_id) == stall_wr_id && int'(mem_wr_slot) == stall_wr_slot,
            "R8", "write held", int'(mem_wr_id), stall_wr_id);
      rr = ($urandom_range(0, 3) != 0);
      wr = ($urandom_range(0, 3) != 0);
      mem_rd_ready = rr;
      mem_wr_ready = wr;
      rd_stall = mem_rd_valid && !rr;
      wr_stall = mem_wr_valid && !wr;
      stall_rd_slot = int'(mem_rd_slot);
      stall_wr_slot = int'(mem_wr_slot);
      stall_wr_id = int'(mem_wr_id);
      if (mem_rd_valid && rr) begin
        chk(int'(mem_rd_slot) == slot_of(cur_want), vict_seen[cur_want] ? "R5" : "R2",
            "read slot", int'(mem_rd_slot), slot_of(cur_want));
        rdat_id = mblk[mem_rd_slot];
        chk(rdat_id == cur_want, "R9", "slot read holds requested block", rdat_id, cur_want);
        mblk[mem_rd_slot] = -1;
        last_rd_slot = int'(mem_rd_slot);
        rdat_cnt = $urandom_range(1, 3);
        rd_cnt++;
      end
      if (mem_wr_valid && wr) begin
        chk(int'(mem_wr_slot) == last_rd_slot, "R4", "write slot", int'(mem_wr_slot), last_rd_slot);
        chk(mblk[mem_wr_slot] == -1, "R9", "write into empty slot", mblk[mem_wr_slot], -1);
        chk(int'(mem_wr_id) != cur_want, "R4", "victim differs from fetched", int'(mem_wr_id), cur_want);
        chk(int'(mem_wr_id) != mru_blk, "R4", "victim not last touched", int'(mem_wr_id), mru_blk);
        chk(res[mem_wr_id], "R7", "victim is resident", int'(res[mem_wr_id]), 1);
        mblk[mem_wr_slot] = int'(mem_wr_id);
        btab[mem_wr_id] = int'(mem_wr_slot);
        res[mem_wr_id] = 1'b0;
        vict_seen[mem_wr_id] = 1'b1;
        wr_cnt++;
      end
    end
  end

  task automatic do_req(input int id);
    int c;
    int rd0;
    int wr0;
    bit exp_hit;
    exp_hit = res[id];
    rd0 = rd_cnt;
    wr0 = wr_cnt;
    cur_want = id;
    req_id = IW'(id);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    c = 1;
    while (!rsp_valid) begin
      @(negedge clk);
      c++;
    end
    chk(int'(rsp_id) == id, exp_hit ? "R6" : "R2", "response id", int'(rsp_id), id);
    if (exp_hit) begin
      chk(c == 1, "R6", "hit latency", c, 1);
      chk(rd_cnt == rd0 && wr_cnt == wr0, "R6", "bus traffic on hit", (rd_cnt - rd0) + (wr_cnt - wr0), 0);
    end else begin
      chk(rd_cnt == rd0 + 1, "R2", "reads per miss", rd_cnt - rd0, 1);
      if (nres < KE) begin
        chk(wr_cnt == wr0, "R3", "writes during fill", wr_cnt - wr0, 0);
        nres++;
      end else begin
        chk(wr_cnt == wr0 + 1, "R4", "writes per full miss", wr_cnt - wr0, 1);
      end
      res[id] = 1'b1;
    end
    mru_blk = id;
    @(negedge clk);
    chk(!rsp_valid, "R2", "response is one pulse", int'(rsp_valid), 0);
  endtask

  task automatic check_map();
    int empties;
    empties = 0;
    for (int b = 0; b < NB; b++) begin
      if (!res[b]) chk(mblk[btab[b]] == b, "R9", "slot holds its block", mblk[btab[b]], b);
    end
    for (int s = 0; s < NB; s++) begin
      if (mblk[s] == -1) empties++;
    end
    chk(empties == nres, "R9", "empty slot count", empties, nres);
  endtask

  initial begin
    int ready_wait;
    void'($urandom(32'd20251));
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!rsp_valid, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
    chk(!mem_rd_valid && !mem_wr_valid, "R1", "bus idle after reset", int'(mem_rd_valid) + int'(mem_wr_valid), 0);
    chk(!req_ready, "R1", "not ready during table sweep", int'(req_ready), 0);
    ready_wait = 1;
    while (!req_ready && ready_wait < 100) begin
      @(negedge clk);
      ready_wait++;
    end
    chk(ready_wait <= NB, "R1", "ready after sweep", ready_wait, NB);

    // Fill: blocks 0..3 read from identity slots, no writes
    for (int i = 0; i < KE; i++) do_req(i);
    check_map();
    do_req(2);                 // hit
    do_req(9);                 // first eviction, victim must not be 2 or 9
    do_req(9);                 // hit right after fetch
    do_req(2);                 // hit or miss depending on the draw
    check_map();

    for (int n = 0; n < 500; n++) begin
      int id;
      if ($urandom_range(0, 1) == 1) id = $urandom_range(0, 5);
      else id = $urandom_range(0, NB - 1);
      do_req(id);
      if (n % 100 == 99) check_map();
    end
    check_map();
    chk($countones(vict_seen) >= 6, "R7", "distinct evicted blocks", $countones(vict_seen), 6);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule